// File: doc/BRIEF.md
# Character-Row Video Address Generator

This block produces the 16-bit screen-memory byte address for every byte slot of the visible picture. Software programs a 14-bit display start value through two byte-wide write strobes. The high byte carries a 16 KB page select and the top of a word offset, and the low byte carries the rest of the offset. The block keeps its own byte-column, raster-line and character-row counters, and it advances them from a byte-clock enable, a line-start strobe and a frame-start strobe that the surrounding timing logic supplies.

The addresses are not linear. The page select forms address bits 15:14 and the raster line inside a character row forms bits 13:11, so each raster line lies 0x800 above the one before it. The low 11 bits are the sum of twice the start offset, 80 times the character row and the byte column, taken modulo 2048. Each 2 KB raster slice therefore wraps on its own, and this is what lets a hardware scroll move the whole picture by changing one start value. A start value that is written takes effect only at the next frame start, so the picture never tears in the middle of a frame.

Top module: `scan_addr_gen`

## Requirements
- R1: After reset all counters and the active start value are zero, so `vaddr` reads 0x0000.
- R2: High-byte data bits 5:4 (start bits 13:12) select the page, and the page appears as `vaddr[15:14]`: 00 gives 0x0000, 01 gives 0x4000, 10 gives 0x8000 and 11 gives 0xC000.
- R3: The 10-bit offset is high-byte data bits 1:0 over low-byte data bits 7:0. At row 0, raster 0, column 0, `vaddr[10:0]` equals twice the offset.
- R4: Each `byte_en` pulse raises the column, and so the address, by one byte. The column stops at 79 until the next line or frame start.
- R5: A `line_start` pulse clears the column and raises the raster line by one. This adds 0x800 to the line start address.
- R6: A `line_start` on raster line 7 returns the raster to 0 and moves to the next character row. This adds 0x50 to the row start address.
- R7: `vaddr[10:0]` is the offset term plus the row term plus the column, taken modulo 2048. It wraps inside the slice and never carries into bit 11.
- R8: A start value that is written is held pending. The address does not change until a `frame_start`. A `frame_start` in the same cycle as a write uses the value that was pending before that write.
- R9: High-byte data bits 7:6 (start bits 15:14) and bits 3:2 (start bits 11:10) have no effect on the address.
- R10: A `frame_start` returns the column, raster and row to zero, and it takes priority over a `line_start` or `byte_en` in the same cycle.
- R11: After character row 24 (25 rows of 8 lines), the next row advance returns to row 0. The row start address becomes the frame's offset term again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_en | input | 1 | Advance one byte column |
| line_start | input | 1 | Start of next raster line |
| frame_start | input | 1 | Start of frame; loads the pending start value |
| start_hi_we | input | 1 | Write the high start byte |
| start_lo_we | input | 1 | Write the low start byte |
| start_data | input | 8 | Start byte write data |
| vaddr | output | 16 | Screen memory byte address |

## Verification
Every strobe and write acts at the clock edge that samples it. `vaddr` is formed combinationally from the registered counters, the row base and the active start value, so any result is due one edge after its stimulus. The bench drives each stimulus on the falling edge and holds it for one cycle. It compares `vaddr` at the next falling edge against an address computed from the page, offset, row, raster and column that each scenario tracks. Tests of deferred writes sample both before and after the frame start that makes them visible.

// File: rtl/scan_addr_pkg.sv
package scan_addr_pkg;
    parameter int LINE_BYTES   = 80;
    parameter int RASTER_LINES = 8;
    parameter int ROWS         = 25;
    parameter int PAGE_W       = 2;
    parameter int OFF_W        = 10;
    parameter int SLICE_W      = 11;
    parameter int ADDR_W       = 16;

    localparam int COL_W = $clog2(LINE_BYTES);
    localparam int RAS_W = $clog2(RASTER_LINES);
    localparam int ROW_W = $clog2(ROWS);
    localparam logic [SLICE_W-1:0] ROW_STRIDE = SLICE_W'(LINE_BYTES);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
    } start_t;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [RAS_W-1:0] raster;
        logic [COL_W-1:0] col;
    } scan_pos_t;

    function automatic logic [SLICE_W-1:0] offset_term(input logic [OFF_W-1:0] off);
        return {off, 1'b0};
    endfunction

    function automatic logic [ADDR_W-1:0] compose_addr(
        input logic [PAGE_W-1:0]  page,
        input logic [RAS_W-1:0]   raster,
        input logic [SLICE_W-1:0] low);
        return {page, raster, low};
    endfunction
endpackage

// File: rtl/scan_start_regs.sv
module scan_start_regs
    import scan_addr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic       hi_we,
    input  logic       lo_we,
    input  logic [7:0] wdata,
    output start_t     active,
    output start_t     next_active
);
    start_t pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
        end else begin
            if (hi_we) begin
                pending.page           <= wdata[5:4];
                pending.off[OFF_W-1:8] <= wdata[OFF_W-9:0];
            end
            if (lo_we) begin
                pending.off[7:0] <= wdata;
            end
        end
    end

    assign next_active = frame_start ? pending : active;

    always_ff @(posedge clk) begin
        if (rst) active <= '0;
        else     active <= next_active;
    end

    // R8
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(active));
endmodule

// File: rtl/scan_pos_counter.sv
module scan_pos_counter
    import scan_addr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      byte_en,
    input  logic      line_start,
    input  logic      frame_start,
    output scan_pos_t pos,
    output logic      row_adv,
    output logic      row_wrap
);
    logic last_col, last_ras, last_row;

    assign last_col = (pos.col    == COL_W'(LINE_BYTES - 1));
    assign last_ras = (pos.raster == RAS_W'(RASTER_LINES - 1));
    assign last_row = (pos.row    == ROW_W'(ROWS - 1));
    assign row_adv  = line_start && !frame_start && last_ras;
    assign row_wrap = row_adv && last_row;

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            pos <= '0;
        end else if (line_start) begin
            pos.col <= '0;
            if (last_ras) begin
                pos.raster <= '0;
                pos.row    <= last_row ? '0 : pos.row + 1'b1;
            end else begin
                pos.raster <= pos.raster + 1'b1;
            end
        end else if (byte_en && !last_col) begin
            pos.col <= pos.col + 1'b1;
        end
    end

    // R4
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        byte_en && !line_start && !frame_start && (pos.col < COL_W'(LINE_BYTES - 1))
        |=> pos.col == $past(pos.col) + 1'b1);

    // R5
    raster_step_chk: assert property (@(posedge clk) disable iff (rst)
        line_start && !frame_start && (pos.raster != RAS_W'(RASTER_LINES - 1))
        |=> (pos.raster == $past(pos.raster) + 1'b1) && (pos.col == '0));

    // R10
    frame_home_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> pos == '0);
endmodule

// File: rtl/scan_addr_compose.sv
module scan_addr_compose
    import scan_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              row_adv,
    input  logic              row_wrap,
    input  start_t            active,
    input  start_t            next_active,
    input  scan_pos_t         pos,
    output logic [ADDR_W-1:0] vaddr
);
    logic [SLICE_W-1:0] row_base;
    logic [SLICE_W-1:0] slice_low;

    always_ff @(posedge clk) begin
        if (rst)            row_base <= '0;
        else if (frame_start) row_base <= offset_term(next_active.off);
        else if (row_wrap)  row_base <= offset_term(active.off);
        else if (row_adv)   row_base <= row_base + ROW_STRIDE;
    end

    assign slice_low = row_base + SLICE_W'(pos.col);
    assign vaddr     = compose_addr(active.page, pos.raster, slice_low);

    // R6
    row_step_chk: assert property (@(posedge clk) disable iff (rst)
        row_adv && !row_wrap |=> row_base == $past(row_base) + ROW_STRIDE);

    // R11
    row_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        row_wrap |=> row_base == offset_term(active.off));
endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
    import scan_addr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        byte_en,
    input  logic        line_start,
    input  logic        frame_start,
    input  logic        start_hi_we,
    input  logic        start_lo_we,
    input  logic [7:0]  start_data,
    output logic [15:0] vaddr
);
    start_t    active, next_active;
    scan_pos_t pos;
    logic      row_adv, row_wrap;

    scan_start_regs u_regs (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .hi_we(start_hi_we), .lo_we(start_lo_we), .wdata(start_data),
        .active(active), .next_active(next_active)
    );

    scan_pos_counter u_cnt (
        .clk(clk), .rst(rst), .byte_en(byte_en), .line_start(line_start),
        .frame_start(frame_start), .pos(pos), .row_adv(row_adv), .row_wrap(row_wrap)
    );

    scan_addr_compose u_cmp (
        .clk(clk), .rst(rst), .frame_start(frame_start), .row_adv(row_adv),
        .row_wrap(row_wrap), .active(active), .next_active(next_active),
        .pos(pos), .vaddr(vaddr)
    );

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> vaddr == 16'h0000);
endmodule

// File: tb/scan_addr_gen_test.sv
module scan_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_en = 1'b0, line_start = 1'b0, frame_start = 1'b0;
    logic        start_hi_we = 1'b0, start_lo_we = 1'b0;
    logic [7:0]  start_data = 8'h00;
    logic [15:0] vaddr;
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    scan_addr_gen uut (
        .clk(clk), .rst(rst), .byte_en(byte_en), .line_start(line_start),
        .frame_start(frame_start), .start_hi_we(start_hi_we),
        .start_lo_we(start_lo_we), .start_data(start_data), .vaddr(vaddr)
    );

    function automatic logic [15:0] model(input int page, input int off,
                                          input int row, input int ras, input int col);
        logic [10:0] low;
        low = 11'((off * 2 + row * 80 + col) % 2048);
        return {2'(page), 3'(ras), low};
    endfunction

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if (vaddr !== exp) begin
            fails++;
            $display("FAIL %s: vaddr=%h expected=%h", req, vaddr, exp);
        end
    endtask

    task automatic pulse(input logic be, input logic ls, input logic fs);
        byte_en = be; line_start = ls; frame_start = fs;
        @(negedge clk);
        byte_en = 1'b0; line_start = 1'b0; frame_start = 1'b0;
    endtask

    task automatic write_hi(input logic [7:0] d);
        start_hi_we = 1'b1; start_data = d;
        @(negedge clk);
        start_hi_we = 1'b0;
    endtask

    task automatic write_lo(input logic [7:0] d);
        start_lo_we = 1'b1; start_data = d;
        @(negedge clk);
        start_lo_we = 1'b0;
    endtask

    task automatic lines(input int n);
        for (int i = 0; i < n; i++) pulse(1'b0, 1'b1, 1'b0);
    endtask

    task automatic bytes(input int n);
        for (int i = 0; i < n; i++) pulse(1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        check("R1 reset", 16'h0000);
    endtask

    task automatic t_pages;
        write_hi(8'h30); write_lo(8'h00);
        check("R8 pending before frame", 16'h0000);
        for (int p = 0; p < 4; p++) begin
            write_hi(8'(p << 4));
            pulse(1'b0, 1'b0, 1'b1);
            check("R2 page select", model(p, 0, 0, 0, 0));
        end
    endtask

    task automatic t_columns_lines;
        bytes(5);
        check("R4 column step", model(3, 0, 0, 0, 5));
        bytes(100);
        check("R4 column saturates", model(3, 0, 0, 0, 79));
        lines(1);
        check("R5 raster stride", model(3, 0, 0, 1, 0));
        lines(6);
        check("R5 raster 7", model(3, 0, 0, 7, 0));
        lines(1);
        check("R6 next row", 16'hC050);
        bytes(1);
        check("R6 next row column", 16'hC051);
    endtask

    task automatic t_frame_priority;
        bytes(3);
        pulse(1'b1, 1'b1, 1'b1);
        check("R10 frame priority", 16'hC000);
    endtask

    task automatic t_row_wrap;
        lines(24 * 8);
        check("R11 last row", 16'hC780);
        lines(8);
        check("R11 row wraps", 16'hC000);
    endtask

    task automatic t_slice_wrap;
        write_hi(8'h33); write_lo(8'hFF);
        pulse(1'b0, 1'b0, 1'b1);
        check("R3 offset term", 16'hC7FE);
        bytes(3);
        check("R7 column wrap", 16'hC001);
        lines(8);
        check("R7 row wrap in slice", 16'hC04E);
    endtask

    task automatic t_ignored_bits;
        write_hi(8'hCC); write_lo(8'h00);
        pulse(1'b0, 1'b0, 1'b1);
        check("R9 bits 15:14 11:10 ignored", 16'h0000);
        write_hi(8'hD1);
        pulse(1'b0, 1'b0, 1'b1);
        check("R9 page1 offset 0x100", 16'h4200);
    endtask

    task automatic t_deferred;
        write_lo(8'h10);
        lines(1);
        check("R8 mid-frame write held", 16'h4A00);
        pulse(1'b0, 1'b0, 1'b1);
        check("R8 applied at frame", 16'h4220);
        start_hi_we = 1'b1; start_data = 8'h20; frame_start = 1'b1;
        @(negedge clk);
        start_hi_we = 1'b0; frame_start = 1'b0;
        check("R8 same-cycle write uses old", 16'h4220);
        pulse(1'b0, 1'b0, 1'b1);
        check("R8 next frame new value", 16'h8020);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pages();
        t_columns_lines();
        t_frame_priority();
        t_row_wrap();
        t_slice_wrap();
        t_ignored_bits();
        t_deferred();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule